// File: doc/BRIEF.md
# Four-Segment Tapped Serial Shift Register

The block holds eighteen single-bit storage stages split into four serial segments that all advance on the falling edge of one shared clock. Segments A and B are short (four stages by default), and segments C and D are long (five stages by default). Each segment shifts its own serial input into its first stage, and every stored bit moves one place toward the segment's far end on each falling edge. The short segments show only their final stage. The long segments show both their final stage and the stage just before it.

A link-mode input joins the segments end to end in the order A, B, C, D. This forms a single register of the full length, so no external wiring is needed. The serial input of segment A feeds the joined register, and the final stage of D is its serial output. Shorter lengths can be taken from any visible tap. An active-high synchronous clear, sampled on the falling edge, zeroes every stage and takes priority over shifting. All outputs come directly from flip-flops, so they can change only just after a falling clock edge.

Top module: `quad_tap_shreg`

## Requirements
- R1: When `clr` is high at a falling edge of `clk`, all eighteen stages become 0, so every output reads 0 after that edge.
- R2: Stage contents and outputs change only on a falling edge of `clk`. Input changes and rising edges between falling edges leave every output unchanged.
- R3: With `chain` low, a bit on `sin_a` (or `sin_b`) at a falling edge appears on `q_a` (or `q_b`) after exactly SHORT_LEN falling edges (4 by default).
- R4: With `chain` low, a bit on `sin_c` (or `sin_d`) appears on `q_c_mid` (or `q_d_mid`) after LONG_LEN-1 falling edges and on `q_c` (or `q_d`) after LONG_LEN falling edges (4 and 5 by default).
- R5: With `chain` high, the first stage of B loads the final stage of A, C loads from B, and D loads from C, and `sin_b`, `sin_c` and `sin_d` are ignored. `sin_a` still feeds A.
- R6: With `chain` high for the whole run, a bit on `sin_a` appears on `q_d_mid` after 17 falling edges and on `q_d` after 18 falling edges.
- R7: The clear wins over shifting: a falling edge with `clr` high gives all-zero outputs whatever the data and `chain` inputs are.
- R8: With `chain` low, each segment's outputs depend only on its own serial input. Activity on one input never changes another segment's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages advance on its falling edge |
| clr | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| chain | input | 1 | 1 = segments joined A→B→C→D; 0 = segments independent |
| sin_a | input | 1 | Serial input of segment A (and of the joined register) |
| sin_b | input | 1 | Serial input of segment B, used when `chain` is 0 |
| sin_c | input | 1 | Serial input of segment C, used when `chain` is 0 |
| sin_d | input | 1 | Serial input of segment D, used when `chain` is 0 |
| q_a | output | 1 | Final stage of segment A |
| q_b | output | 1 | Final stage of segment B |
| q_c_mid | output | 1 | Next-to-last stage of segment C |
| q_c | output | 1 | Final stage of segment C |
| q_d_mid | output | 1 | Next-to-last stage of segment D |
| q_d | output | 1 | Final stage of segment D; serial output in joined mode |

## Verification
The bench builds the block with its default lengths of 4, 4, 5 and 5 stages, which keep the full eighteen-bit state small enough to predict completely. Every segment input combination is swept through the independent mode. Long random streams run in the joined mode, with the mode switched partway through a stream. Single-bit impulse runs measure the 4-, 5-, 17- and 18-edge latencies directly.

// File: rtl/qts_pkg.sv
package qts_pkg;

    localparam int NUM_SEG = 4;

    typedef enum logic {
        LINK_SPLIT = 1'b0,
        LINK_CHAIN = 1'b1
    } link_mode_e;

    // segments 0 and 1 are short, 2 and 3 are long
    function automatic int seg_len(input int idx, input int short_len, input int long_len);
        return (idx < 2) ? short_len : long_len;
    endfunction

    // number of visible taps counted back from the far end of a segment
    function automatic int seg_taps(input int idx);
        return (idx < 2) ? 1 : 2;
    endfunction

endpackage

// File: rtl/qts_segment.sv
module qts_segment #(
    parameter int LEN  = 4,
    parameter int NTAP = 1
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            sin,
    output logic [NTAP-1:0] taps
);

    logic [LEN-1:0] st;

    always_ff @(negedge clk) begin
        if (clr) begin
            st <= '0;
        end else begin
            st <= {st[LEN-2:0], sin};
        end
    end

    // tap k is the stage k places before the far end
    for (genvar k = 0; k < NTAP; k++) begin : gen_tap
        assign taps[k] = st[LEN-1-k];
    end

    // R1: a clear leaves every stage at zero
    p_clear_zero_r1: assert property (@(negedge clk) disable iff (clr)
        $past(clr) |-> (st == '0));

    // R2: first stage takes the value presented at the previous falling edge
    p_load_first_r2: assert property (@(negedge clk) disable iff (clr)
        !$past(clr) |-> (st[0] == $past(sin)));

    // R2: every other stage takes its neighbour's previous value
    p_shift_step_r2: assert property (@(negedge clk) disable iff (clr)
        !$past(clr) |-> (st[LEN-1:1] == $past(st[LEN-2:0])));

endmodule

// File: rtl/qts_link_mux.sv
module qts_link_mux
    import qts_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  link_mode_e      mode,
    input  logic [NSEG-1:0] ext_in,
    input  logic [NSEG-2:0] prev_last,
    output logic [NSEG-1:0] feed
);

    assign feed[0] = ext_in[0];

    for (genvar i = 1; i < NSEG; i++) begin : gen_link
        assign feed[i] = (mode == LINK_CHAIN) ? prev_last[i-1] : ext_in[i];
    end

endmodule

// File: rtl/quad_tap_shreg.sv
module quad_tap_shreg
    import qts_pkg::*;
#(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic chain,
    input  logic sin_a,
    input  logic sin_b,
    input  logic sin_c,
    input  logic sin_d,
    output logic q_a,
    output logic q_b,
    output logic q_c_mid,
    output logic q_c,
    output logic q_d_mid,
    output logic q_d
);

    link_mode_e         mode;
    logic [NUM_SEG-1:0] ext_in;
    logic [NUM_SEG-1:0] feed;
    logic [NUM_SEG-1:0] seg_last;

    assign mode   = chain ? LINK_CHAIN : LINK_SPLIT;
    assign ext_in = {sin_d, sin_c, sin_b, sin_a};

    qts_link_mux #(
        .NSEG(NUM_SEG)
    ) u_link (
        .mode     (mode),
        .ext_in   (ext_in),
        .prev_last(seg_last[NUM_SEG-2:0]),
        .feed     (feed)
    );

    for (genvar i = 0; i < NUM_SEG; i++) begin : gen_seg
        localparam int LEN_I = seg_len(i, SHORT_LEN, LONG_LEN);
        localparam int NT_I  = seg_taps(i);

        logic [NT_I-1:0] taps;

        qts_segment #(
            .LEN (LEN_I),
            .NTAP(NT_I)
        ) u_seg (
            .clk (clk),
            .clr (clr),
            .sin (feed[i]),
            .taps(taps)
        );

        assign seg_last[i] = taps[0];

        if (i > 0) begin : gen_link_chk
            // R5: joined mode loads each segment from its predecessor's end
            p_chain_feed_r5: assert property (@(negedge clk) disable iff (clr)
                (!$past(clr) && $past(chain)) |-> (u_seg.st[0] == $past(seg_last[i-1])));

            // R8: split mode loads each segment from its own pin only
            p_split_feed_r8: assert property (@(negedge clk) disable iff (clr)
                (!$past(clr) && !$past(chain)) |-> (u_seg.st[0] == $past(ext_in[i])));
        end
    end

    assign q_a     = seg_last[0];
    assign q_b     = seg_last[1];
    assign q_c     = seg_last[2];
    assign q_d     = seg_last[3];
    assign q_c_mid = gen_seg[2].taps[1];
    assign q_d_mid = gen_seg[3].taps[1];

    // R4: the final tap of a long segment trails its middle tap by one edge
    p_tap_order_r4: assert property (@(negedge clk) disable iff (clr)
        !$past(clr) |-> ((q_c == $past(q_c_mid)) && (q_d == $past(q_d_mid))));

endmodule

// File: tb/quad_tap_shreg_tb.sv
`timescale 1ns/1ps
module quad_tap_shreg_tb;

    logic clk = 1'b0;
    logic clr, chain, sin_a, sin_b, sin_c, sin_d;
    logic q_a, q_b, q_c_mid, q_c, q_d_mid, q_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model: bits 0..3 A, 4..7 B, 8..12 C, 13..17 D (stage 0 first)
    logic [17:0] m;

    always #2.5 clk = ~clk;

    quad_tap_shreg u_dut (
        .clk(clk), .clr(clr), .chain(chain),
        .sin_a(sin_a), .sin_b(sin_b), .sin_c(sin_c), .sin_d(sin_d),
        .q_a(q_a), .q_b(q_b), .q_c_mid(q_c_mid), .q_c(q_c),
        .q_d_mid(q_d_mid), .q_d(q_d)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string ra, input string rb, input string rc, input string rd);
        chk(ra, "q_a",     q_a,     m[3]);
        chk(rb, "q_b",     q_b,     m[7]);
        chk(rc, "q_c_mid", q_c_mid, m[11]);
        chk(rc, "q_c",     q_c,     m[12]);
        chk(rd, "q_d_mid", q_d_mid, m[16]);
        chk(rd, "q_d",     q_d,     m[17]);
    endtask

    // drive after the rising edge, confirm no change (R2), then apply the falling edge
    task automatic tick(input logic [3:0] din, input logic ch, input logic cl);
        @(posedge clk);
        #1;
        sin_a = din[0]; sin_b = din[1]; sin_c = din[2]; sin_d = din[3];
        chain = ch; clr = cl;
        #0.5;
        chk_all("R2", "R2", "R2", "R2");
        @(negedge clk);
        if (cl) begin
            m = '0;
        end else if (ch) begin
            m = {m[16:0], din[0]};
        end else begin
            m = {m[16:13], din[3], m[11:8], din[2], m[6:4], din[1], m[2:0], din[0]};
        end
        #1;
        if (cl)      chk_all("R7", "R7", "R7", "R7");
        else if (ch) chk_all("R3", "R5", "R5", "R6");
        else         chk_all("R3", "R3", "R4", "R4");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        m = 'x;
        clr = 1'b1; chain = 1'b0;
        sin_a = 1'b0; sin_b = 1'b0; sin_c = 1'b0; sin_d = 1'b0;
        repeat (3) @(negedge clk);
        m = '0;
        #1;
        // R1: reset state
        chk("R1", "q_a", q_a, 1'b0);
        chk("R1", "q_b", q_b, 1'b0);
        chk("R1", "q_c_mid", q_c_mid, 1'b0);
        chk("R1", "q_c", q_c, 1'b0);
        chk("R1", "q_d_mid", q_d_mid, 1'b0);
        chk("R1", "q_d", q_d, 1'b0);

        // R3/R4: impulse on every input in split mode, latency counted
        tick(4'b1111, 1'b0, 1'b0);
        for (int e = 2; e <= 6; e++) begin
            tick(4'b0000, 1'b0, 1'b0);
            chk("R3", "q_a impulse", q_a, (e == 4));
            chk("R3", "q_b impulse", q_b, (e == 4));
            chk("R4", "q_c_mid impulse", q_c_mid, (e == 4));
            chk("R4", "q_c impulse", q_c, (e == 5));
            chk("R4", "q_d_mid impulse", q_d_mid, (e == 4));
            chk("R4", "q_d impulse", q_d, (e == 5));
        end

        // R8: only sin_c active, other segments stay zero
        tick(4'b0000, 1'b0, 1'b1);
        for (int e = 0; e < 10; e++) begin
            tick(4'b0100, 1'b0, 1'b0);
            chk("R8", "q_a isolation", q_a, 1'b0);
            chk("R8", "q_b isolation", q_b, 1'b0);
            chk("R8", "q_d isolation", q_d, 1'b0);
        end

        // split-mode sweep of every input combination pair
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = i[7:0];
            tick(v[3:0] ^ v[7:4], 1'b0, 1'b0);
            tick(v[7:4], 1'b0, 1'b0);
        end

        // R7: fill with ones, clear while inputs and chain are high
        for (int e = 0; e < 20; e++) tick(4'b1111, 1'b1, 1'b0);
        tick(4'b1111, 1'b1, 1'b1);
        chk("R7", "q_d after clear", q_d, 1'b0);
        chk("R7", "q_a after clear", q_a, 1'b0);

        // R6: joined-mode impulse with toggling, ignored b/c/d pins
        tick(4'b1111, 1'b1, 1'b0);
        for (int e = 2; e <= 19; e++) begin
            tick({3'($urandom), 1'b0}, 1'b1, 1'b0);
            chk("R6", "q_d_mid impulse", q_d_mid, (e == 17));
            chk("R6", "q_d impulse", q_d, (e == 18));
        end

        // joined-mode random stream with mode switches partway
        for (int i = 0; i < 600; i++) begin
            tick(4'($urandom), ((i / 150) % 2 == 0), (i == 450));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule